// File: doc/BRIEF.md
# Table-Driven Softmax Normaliser

This block turns one row of signed 8-bit attention scores, as produced by quantized integer dot products, into a row of probability weights. Exponent and division hardware are replaced by two constant tables of 256 entries each, built as combinational mux trees. The first table holds the exponential of the distance below the row maximum. The second holds the reciprocal of the normalised row sum.

Scores stream in with a last flag and are held in an internal buffer while the running maximum is tracked. A second pass looks up each exponent and adds it to the row sum. A single normalise cycle finds the leading one of the sum and keeps 8 index bits for the reciprocal lookup. A third pass multiplies each exponent by that reciprocal, applies the saved shift, and streams the weights out in input order, one per cycle. A downstream stage uses them to weight the value vectors.

Top module: `lut_softmax`

## Requirements
- R1: While reset is high and in the first cycle after it falls, in_ready is 1 and out_valid and out_last are 0.
- R2: A score is taken on a rising edge where in_valid and in_ready are both 1. Taking a score with in_last = 1 closes the row. in_ready stays 0 from the next cycle until the row's last weight has been presented, and out_valid is never 1 while in_ready is 1.
- R3: A row that reaches DEPTH scores without in_last is closed by its DEPTH-th score. The following scores start a new row.
- R4: Each score s in a row with maximum M (signed compare) gets exponent E(d), with d = M - s in 0..255. E(d) = F[d mod 16] >> (d div 16), where F[i] = floor(65535 * 2^(-i/16)). The largest entry is E(0) = 65535 and the smallest is E(255) = 1.
- R5: The row sum S of the exponents has its leading one at bit p. The reciprocal index is m = S >> (p - 7), in 128..255, and R(m) = floor(2^24 / m). Each weight is min(65535, (E * R(m)) >> (p + 1)), an unsigned Q0.16 value.
- R6: The weights of a row of L scores come out on L consecutive cycles, in input order. out_last is 1 on the L-th weight only, and in_ready returns to 1 the cycle after.
- R7: The weights of every row add up to within 2048 of 65536.
- R8: Given a row of L scores, out_valid first rises on the (L+1)-th rising edge after the edge that took the row's final score.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A score is offered |
| in_score | input | 8 | Signed attention score |
| in_last | input | 1 | The offered score ends its row |
| in_ready | output | 1 | The unit is collecting scores |
| out_valid | output | 1 | out_weight holds a weight |
| out_weight | output | 16 | Normalised weight, unsigned Q0.16 |
| out_last | output | 1 | This weight ends its row |

## Verification
The assertions check on every cycle that the collect and emit phases exclude each other. They also check that a closing score, whether flagged or forced by the depth limit, drops in_ready on the next cycle, and that a row's weights form one unbroken burst whose final beat hands control back to input. In the emit phase, the reciprocal index must always have its top bit set. The weight values, their order, the latency to the first weight and the per-row sum tolerance can only be shown by the bench's scenarios. These include single-score rows, uniform rows, rows spanning the full score range and rows longer than the buffer, each compared with independently computed table values.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

    localparam int SCORE_W = 8;
    localparam int IDX_W   = 8;
    localparam int LUT_N   = 1 << IDX_W;
    localparam int EXP_W   = 16;
    localparam int RECIP_W = 18;
    localparam int RECIP_Q = 24;
    localparam int PROD_W  = EXP_W + RECIP_W;
    localparam int SHIFT_W = 6;

    typedef enum logic [1:0] {
        PH_COLLECT,
        PH_ACCUM,
        PH_NORM,
        PH_EMIT
    } phase_e;

    typedef struct packed {
        logic [IDX_W-1:0]   mant;
        logic [SHIFT_W-1:0] shift;
    } norm_t;

    // floor(65535 * 2^(-i/16)) for one octave
    function automatic logic [EXP_W-1:0] octave_frac(input int i);
        case (i)
            0:  return 16'd65535;
            1:  return 16'd62756;
            2:  return 16'd60095;
            3:  return 16'd57548;
            4:  return 16'd55108;
            5:  return 16'd52771;
            6:  return 16'd50534;
            7:  return 16'd48392;
            8:  return 16'd46340;
            9:  return 16'd44375;
            10: return 16'd42494;
            11: return 16'd40692;
            12: return 16'd38967;
            13: return 16'd37315;
            14: return 16'd35733;
            15: return 16'd34218;
            default: return 16'd0;
        endcase
    endfunction

    function automatic logic [EXP_W-1:0] exp_entry(input int d);
        return octave_frac(d % 16) >> (d / 16);
    endfunction

    function automatic logic [RECIP_W-1:0] recip_entry(input int m);
        int r;
        if (m < LUT_N / 2) r = 0;
        else               r = (1 << RECIP_Q) / m;
        return RECIP_W'(r);
    endfunction

endpackage

// File: rtl/lsm_exp_rom.sv
module lsm_exp_rom
    import lsm_pkg::*;
(
    input  logic [IDX_W-1:0] index,
    output logic [EXP_W-1:0] value
);
    logic [EXP_W-1:0] rom [LUT_N];

    for (genvar g = 0; g < LUT_N; g++) begin : g_rom
        assign rom[g] = exp_entry(g);
    end

    assign value = rom[index];
endmodule

// File: rtl/lsm_recip_rom.sv
module lsm_recip_rom
    import lsm_pkg::*;
(
    input  logic [IDX_W-1:0]   index,
    output logic [RECIP_W-1:0] value
);
    logic [RECIP_W-1:0] rom [LUT_N];

    for (genvar g = 0; g < LUT_N; g++) begin : g_rom
        assign rom[g] = recip_entry(g);
    end

    assign value = rom[index];
endmodule

// File: rtl/lsm_normaliser.sv
module lsm_normaliser
    import lsm_pkg::*;
#(
    parameter int SUM_W = 21
) (
    input  logic [SUM_W-1:0] sum,
    output norm_t            norm
);
    int               lead;
    logic [SUM_W-1:0] aligned;

    always_comb begin
        lead = 0;
        for (int i = 0; i < SUM_W; i++) begin
            if (sum[i]) lead = i;
        end
        if (lead >= IDX_W - 1) aligned = sum >> (lead - (IDX_W - 1));
        else                   aligned = sum << ((IDX_W - 1) - lead);
        norm.mant  = aligned[IDX_W-1:0];
        norm.shift = SHIFT_W'(lead + 1);
    end
endmodule

// File: rtl/lut_softmax.sv
module lut_softmax
    import lsm_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic signed [7:0]  in_score,
    input  logic               in_last,
    output logic               in_ready,
    output logic               out_valid,
    output logic [15:0]        out_weight,
    output logic               out_last
);
    localparam int IX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int SUM_W = EXP_W + IX_W + 1;

    phase_e                    phase_q;
    logic signed [SCORE_W-1:0] buf_q [DEPTH];
    logic signed [SCORE_W-1:0] row_max_q;
    logic [IX_W-1:0]           wr_cnt_q;
    logic [IX_W-1:0]           rd_idx_q;
    logic [IX_W-1:0]           last_idx_q;
    logic [SUM_W-1:0]          sum_q;
    norm_t                     norm_q;

    logic                      take;
    logic                      row_close;
    logic signed [SCORE_W-1:0] cur_score;
    logic [SCORE_W:0]          gap;
    logic [EXP_W-1:0]          exp_val;
    logic [RECIP_W-1:0]        recip_val;
    norm_t                     norm_d;
    logic [PROD_W-1:0]         product;
    logic [PROD_W-1:0]         scaled;

    assign take      = in_valid && in_ready;
    assign row_close = in_last || (wr_cnt_q == IX_W'(DEPTH - 1));
    assign cur_score = buf_q[rd_idx_q];
    assign gap       = {row_max_q[SCORE_W-1], row_max_q} - {cur_score[SCORE_W-1], cur_score};

    lsm_exp_rom u_exp_rom (
        .index (gap[IDX_W-1:0]),
        .value (exp_val)
    );

    lsm_normaliser #(.SUM_W(SUM_W)) u_norm (
        .sum  (sum_q),
        .norm (norm_d)
    );

    lsm_recip_rom u_recip_rom (
        .index (norm_q.mant),
        .value (recip_val)
    );

    always_ff @(posedge clk) begin
        if (take) buf_q[wr_cnt_q] <= in_score;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q    <= PH_COLLECT;
            row_max_q  <= '0;
            wr_cnt_q   <= '0;
            rd_idx_q   <= '0;
            last_idx_q <= '0;
            sum_q      <= '0;
            norm_q     <= '0;
        end else begin
            case (phase_q)
                PH_COLLECT: if (take) begin
                    if (wr_cnt_q == '0 || in_score > row_max_q) row_max_q <= in_score;
                    if (row_close) begin
                        last_idx_q <= wr_cnt_q;
                        rd_idx_q   <= '0;
                        sum_q      <= '0;
                        phase_q    <= PH_ACCUM;
                    end else begin
                        wr_cnt_q <= wr_cnt_q + 1'b1;
                    end
                end
                PH_ACCUM: begin
                    sum_q <= sum_q + SUM_W'(exp_val);
                    if (rd_idx_q == last_idx_q) phase_q  <= PH_NORM;
                    else                        rd_idx_q <= rd_idx_q + 1'b1;
                end
                PH_NORM: begin
                    norm_q   <= norm_d;
                    rd_idx_q <= '0;
                    phase_q  <= PH_EMIT;
                end
                default: begin
                    if (rd_idx_q == last_idx_q) begin
                        wr_cnt_q <= '0;
                        phase_q  <= PH_COLLECT;
                    end else begin
                        rd_idx_q <= rd_idx_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign product    = PROD_W'(exp_val) * PROD_W'(recip_val);
    assign scaled     = product >> norm_q.shift;
    assign out_weight = (|scaled[PROD_W-1:EXP_W]) ? {EXP_W{1'b1}} : scaled[EXP_W-1:0];
    assign in_ready   = (phase_q == PH_COLLECT);
    assign out_valid  = (phase_q == PH_EMIT);
    assign out_last   = out_valid && (rd_idx_q == last_idx_q);

    p_phase_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(in_ready && out_valid));

    p_last_closes_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> !in_ready);

    p_depth_closes_r3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && wr_cnt_q == IX_W'(DEPTH - 1)) |=> !in_ready);

    p_burst_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);

    p_handback_r6: assert property (@(posedge clk) disable iff (rst)
        out_last |=> (in_ready && !out_valid));

    p_mant_top_r5: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> norm_q.mant[IDX_W-1]);
endmodule

// File: tb/lut_softmax_bench.sv
`timescale 1ns/1ps
module lut_softmax_bench;
    localparam int DEPTH = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic signed [7:0] in_score = '0;
    logic              in_last = 1'b0;
    logic              in_ready;
    logic              out_valid;
    logic [15:0]       out_weight;
    logic              out_last;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    int    exp_w_q[$];
    bit    exp_l_q[$];
    int    first_cyc_q[$];
    string tag_q[$];
    int    pend[$];
    bit    first_beat = 1'b1;
    int    row_sum = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    lut_softmax #(.DEPTH(DEPTH)) u_lut_softmax (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_score(in_score),
        .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
        .out_weight(out_weight), .out_last(out_last)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int frac_ref(input int i);
        int t[16] = '{65535, 62756, 60095, 57548, 55108, 52771, 50534, 48392,
                      46340, 44375, 42494, 40692, 38967, 37315, 35733, 34218};
        return t[i];
    endfunction

    function automatic int e_ref(input int d);
        return frac_ref(d % 16) >> (d / 16);
    endfunction

    // Model one closed row and queue its expected beats
    task automatic model_row(input int drive_cyc, input string tag);
        int mx, s, p, m, r, v;
        longint prod;
        mx = pend[0];
        foreach (pend[k]) if (pend[k] > mx) mx = pend[k];
        s = 0;
        foreach (pend[k]) s += e_ref(mx - pend[k]);
        p = 0;
        for (int b = 0; b < 31; b++) if ((s >> b) & 1) p = b;
        m = s >> (p - 7);
        r = (1 << 24) / m;
        foreach (pend[k]) begin
            prod = longint'(e_ref(mx - pend[k])) * r;
            v = int'(prod >> (p + 1));
            exp_w_q.push_back(v > 65535 ? 65535 : v);
            exp_l_q.push_back(k == pend.size() - 1);
            tag_q.push_back(tag);
        end
        first_cyc_q.push_back(drive_cyc + pend.size() + 2);
        pend.delete();
    endtask

    task automatic push_score(input int s, input bit last, input bit gap);
        @(negedge clk);
        if (gap) begin
            in_valid = 1'b0;
            @(negedge clk);
        end
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_score = 8'(s);
        in_last  = last;
        pend.push_back(s);
        if (last) model_row(cyc, "R4/R5/R6");
        else if (pend.size() == DEPTH) model_row(cyc, "R3/R6");
    endtask

    task automatic idle_wait();
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        while (exp_w_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (first_beat) begin
                check(cyc == first_cyc_q[0], "R8 first-weight cycle", cyc, first_cyc_q[0]);
                void'(first_cyc_q.pop_front());
                first_beat = 1'b0;
                row_sum = 0;
            end
            check(!in_ready, "R2 in_ready low while emitting", int'(in_ready), 0);
            check(int'(out_weight) == exp_w_q[0], {tag_q[0], " weight"}, int'(out_weight), exp_w_q[0]);
            check(out_last == exp_l_q[0], {tag_q[0], " last flag"}, int'(out_last), int'(exp_l_q[0]));
            row_sum += int'(out_weight);
            if (exp_l_q[0]) begin
                check(row_sum >= 65536 - 2048 && row_sum <= 65536 + 2048,
                      "R7 row sum", row_sum, 65536);
                first_beat = 1'b1;
            end
            void'(exp_w_q.pop_front());
            void'(exp_l_q.pop_front());
            void'(tag_q.pop_front());
        end
    end

    initial begin
        void'($urandom(32'h1B5F));
        repeat (3) @(negedge clk);
        check(in_ready === 1'b1, "R1 in_ready in reset", int'(in_ready), 1);
        check(out_valid === 1'b0 && out_last === 1'b0, "R1 outputs idle in reset", int'(out_valid), 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready === 1'b1 && out_valid === 1'b0, "R1 state after reset", int'(out_valid), 0);

        // single score: saturated weight
        push_score(5, 1'b1, 1'b0);
        idle_wait();
        // uniform row
        for (int k = 0; k < 4; k++) push_score(-20, k == 3, 1'b0);
        idle_wait();
        // full range, distance 255
        push_score(127, 1'b0, 1'b0);
        push_score(-128, 1'b0, 1'b0);
        push_score(0, 1'b1, 1'b0);
        idle_wait();
        // maximum not first
        push_score(-3, 1'b0, 1'b0);
        push_score(40, 1'b0, 1'b1);
        push_score(24, 1'b1, 1'b0);
        idle_wait();
        // longer than DEPTH without in_last: forced close, remainder forms new row
        for (int k = 0; k < DEPTH + 3; k++) push_score(k * 7 - 60, k == DEPTH + 2, 1'b0);
        idle_wait();
        // exactly DEPTH with in_last on the final score
        for (int k = 0; k < DEPTH; k++) push_score(100 - k * 13, k == DEPTH - 1, 1'b0);
        idle_wait();

        // random rows, wide and narrow spreads, with input gaps
        for (int row = 0; row < 60; row++) begin
            int len, base, spread;
            len    = 1 + int'($urandom_range(DEPTH - 1));
            spread = (row % 3 == 0) ? 8 : 255;
            base   = -128 + int'($urandom_range(255 - spread));
            for (int k = 0; k < len; k++)
                push_score(base + int'($urandom_range(spread)), k == len - 1,
                           $urandom_range(3) == 0);
            if (row % 4 == 0) idle_wait();
        end
        idle_wait();
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule